// File: doc/BRIEF.md
# Dead-Time PWM Generator with Input Capture

This block drives five pulse-width-modulated channels from one shared time base. Each channel has a complementary pair of outputs: a high-side output and a low-side output. A 16-bit prescaler slows the system clock down to a period tick. An 8-bit period counter then runs from 0 to 255 on those ticks. Each channel compares the period counter against its own 8-bit duty value. A programmable dead time, counted in system clocks, holds both outputs of a pair low after every change of the compare result. Duty values written by software wait in a shadow register and are copied to the compare stage only when a new period starts.

Two of the channels, channel 0 and channel 4, can be turned into measuring inputs. In that mode the channel's outputs stay low. A synchronised external signal is then timed in system clocks from one rising edge to the next rising edge, which gives the period. It is also timed from a rising edge to the following falling edge, which gives the high time. Each completed measurement raises a ready flag. A second measurement that completes before software has read the first one raises an overflow flag. Software reaches all settings and results through a plain write port and a plain read port.

Top module: `pwm_dt_cap`

## Requirements
- R1: After reset, every out_h and out_l bit is 0, and reads of address 2 (control), address 4 and address 5 (capture words) return 0.
- R2: Address 0 holds the prescaler value P. One PWM period lasts 256*(P+1) clocks.
- R3: Address 8+c holds the 8-bit duty D of channel c. With dead time 0, out_h is high for D*(P+1) clocks per period and out_l is high for the rest of the period. D=0 keeps out_h low for the whole period.
- R4: Address 1 holds the dead time T in clocks. Each change of a channel's compare result holds both of its outputs low for T clocks. This gives out_h a high time of max(0, D*(P+1)-T) per period and out_l a high time of max(0, (256-D)*(P+1)-T) per period when 1<=D<=255. The two outputs of a pair are never high together.
- R5: A duty write takes effect only when the period counter wraps from 255 to 0. A period already running keeps its old duty.
- R6: Control bits [4:0] at address 2 enable channels 0 to 4. A disabled channel drives both of its outputs low.
- R7: Control bit 8 puts channel 0 into capture mode on cap_in[0]. Control bit 9 puts channel 4 into capture mode on cap_in[1]. A channel in capture mode drives both of its outputs low.
- R8: Address 4 returns the capture word of unit 0 and address 5 returns the capture word of unit 1. The word layout is {ready[31], high[30:16], overflow[15], period[14:0]}. The period is the number of clocks between two rising edges. The high time is the number of clocks from a rising edge to the next falling edge. The first rising edge after the mode is enabled only arms the unit and produces no result.
- R9: When a capture completes while ready is still set, overflow is set and the newest values replace the old ones. A read with rd_en of a capture word clears that word's ready and overflow bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe; clears the flags of a capture word that is read |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, a combinational decode of rd_addr |
| cap_in | input | 2 | External signals to measure, for channel 0 and channel 4 |
| out_h | output | 5 | High-side output of each channel |
| out_l | output | 5 | Low-side output of each channel |

## Verification
Four properties are checked on every cycle:
- the two outputs of a pair are never high together;
- a disabled channel, or a channel in capture mode, stays low;
- the active duty changes only in the cycle after a period wrap;
- overflow rises only while ready is already set.

The exact pulse lengths under each combination of prescaler, dead time and duty, including pulses swallowed by dead time, can only be shown by the bench's cycle counts over whole periods. The same holds for the measured period and high time, the overflow case and the clearing on read.

// File: rtl/pwm_dt_cap_pkg.sv
package pwm_dt_cap_pkg;
  localparam int CAP_W = 15;

  localparam logic [3:0] A_PRESC = 4'd0;
  localparam logic [3:0] A_DEAD  = 4'd1;
  localparam logic [3:0] A_CTRL  = 4'd2;
  localparam logic [3:0] A_CAP0  = 4'd4;
  localparam logic [3:0] A_DUTY0 = 4'd8;

  typedef struct packed {
    logic             rdy;
    logic [CAP_W-1:0] high;
    logic             ovf;
    logic [CAP_W-1:0] period;
  } cap_word_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] presc,
  output logic [CNT_W-1:0] per_cnt,
  output logic             wrap
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  always_comb begin
    tick  = (pre_q >= presc);
    pre_d = tick ? '0 : pre_q + 1'b1;
    cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign per_cnt = cnt_q;
  assign wrap    = tick && (cnt_q == '1);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic            en,
  input  logic [DT_W-1:0] dead,
  output logic            out_h,
  output logic            out_l
);
  logic            raw_q;
  logic [DT_W-1:0] dt_q, dt_d;
  logic            quiet;

  always_comb begin
    if (raw != raw_q)  dt_d = dead;
    else if (dt_q != '0) dt_d = dt_q - 1'b1;
    else               dt_d = dt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      dt_q  <= '0;
    end else begin
      raw_q <= raw;
      dt_q  <= dt_d;
    end
  end

  assign quiet = (dt_q != '0);
  assign out_h = en && !quiet && raw_q;
  assign out_l = en && !quiet && !raw_q;
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
  import pwm_dt_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      sig_in,
  input  logic      rd_clr,
  output cap_word_t word
);
  logic [2:0]       sync_q;
  logic             armed_q, armed_d;
  logic [CAP_W-1:0] cnt_q, cnt_d, cnt_inc, hi_tmp_q, hi_tmp_d;
  cap_word_t        word_q, word_d;
  logic             rise, fall, done;

  always_comb begin
    rise     = sync_q[1] && !sync_q[2];
    fall     = !sync_q[1] && sync_q[2];
    cnt_inc  = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    done     = active && rise && armed_q;
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    hi_tmp_d = hi_tmp_q;
    word_d   = word_q;
    if (!active) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (rise) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_inc;
      if (fall) hi_tmp_d = cnt_inc;
    end
    if (done) begin
      word_d.period = cnt_inc;
      word_d.high   = hi_tmp_q;
      word_d.rdy    = 1'b1;
      word_d.ovf    = rd_clr ? 1'b0 : (word_q.ovf || word_q.rdy);
    end else if (rd_clr) begin
      word_d.rdy = 1'b0;
      word_d.ovf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      hi_tmp_q <= '0;
      word_q   <= '0;
    end else begin
      sync_q   <= {sync_q[1:0], sig_in};
      armed_q  <= armed_d;
      cnt_q    <= cnt_d;
      hi_tmp_q <= hi_tmp_d;
      word_q   <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/pwm_dt_cap.sv
module pwm_dt_cap
  import pwm_dt_cap_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 16,
  parameter int DT_W   = 8,
  parameter int CAP_A  = 0,
  parameter int CAP_B  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [PRE_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [1:0]        cap_in,
  output logic [NUM_CH-1:0] out_h,
  output logic [NUM_CH-1:0] out_l
);
  localparam int NUM_CAP = 2;

  logic [1:0]                   rst_pipe_q;
  logic                         rst_sn;
  logic [PRE_W-1:0]             presc_q, presc_d;
  logic [DT_W-1:0]              dead_q, dead_d;
  logic [NUM_CH-1:0]            en_q, en_d;
  logic [NUM_CAP-1:0]           csel_q, csel_d;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_q, duty_d, act_q, act_d;
  logic [CNT_W-1:0]             per_cnt;
  logic                         wrap;
  logic [NUM_CH-1:0]            chan_en, cap_mode;
  cap_word_t                    cap_w [NUM_CAP];
  logic [NUM_CAP-1:0]           cap_rdy, cap_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  always_comb begin
    presc_d = presc_q;
    dead_d  = dead_q;
    en_d    = en_q;
    csel_d  = csel_q;
    duty_d  = duty_q;
    act_d   = wrap ? duty_q : act_q;
    if (wr_en) begin
      if (wr_addr == A_PRESC) presc_d = wr_data;
      if (wr_addr == A_DEAD)  dead_d  = wr_data[DT_W-1:0];
      if (wr_addr == A_CTRL) begin
        en_d   = wr_data[NUM_CH-1:0];
        csel_d = wr_data[8 +: NUM_CAP];
      end
      for (int c = 0; c < NUM_CH; c++)
        if (wr_addr == A_DUTY0 + 4'(c)) duty_d[c] = wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      presc_q <= '0;
      dead_q  <= '0;
      en_q    <= '0;
      csel_q  <= '0;
      duty_q  <= '0;
      act_q   <= '0;
    end else begin
      presc_q <= presc_d;
      dead_q  <= dead_d;
      en_q    <= en_d;
      csel_q  <= csel_d;
      duty_q  <= duty_d;
      act_q   <= act_d;
    end
  end

  pwm_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_sn), .presc(presc_q), .per_cnt(per_cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cap_mode[c] = ((c == CAP_A) && csel_q[0]) || ((c == CAP_B) && csel_q[1]);
    assign chan_en[c]  = en_q[c] && !cap_mode[c];
    pwm_deadband #(.DT_W(DT_W)) db_i (
      .clk(clk), .rst_n(rst_sn), .raw(per_cnt < act_q[c]), .en(chan_en[c]),
      .dead(dead_q), .out_h(out_h[c]), .out_l(out_l[c])
    );
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    pwm_capture cap_i (
      .clk(clk), .rst_n(rst_sn), .active(csel_q[j]), .sig_in(cap_in[j]),
      .rd_clr(rd_en && (rd_addr == A_CAP0 + 4'(j))), .word(cap_w[j])
    );
    assign cap_rdy[j] = cap_w[j].rdy;
    assign cap_ovf[j] = cap_w[j].ovf;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_PRESC) rd_data[PRE_W-1:0] = presc_q;
    if (rd_addr == A_DEAD)  rd_data[DT_W-1:0]  = dead_q;
    if (rd_addr == A_CTRL) begin
      rd_data[NUM_CH-1:0]   = en_q;
      rd_data[8 +: NUM_CAP] = csel_q;
    end
    for (int j = 0; j < NUM_CAP; j++)
      if (rd_addr == A_CAP0 + 4'(j)) rd_data = cap_w[j];
    for (int c = 0; c < NUM_CH; c++)
      if (rd_addr == A_DUTY0 + 4'(c)) rd_data[CNT_W-1:0] = duty_q[c];
  end
endmodule

// File: rtl/pwm_dt_cap_chk.sv
module pwm_dt_cap_chk #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 8,
  parameter int CAP_A  = 0,
  parameter int CAP_B  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            out_h,
  input logic [NUM_CH-1:0]            out_l,
  input logic [NUM_CH-1:0]            chan_en,
  input logic [1:0]                   csel,
  input logic                         wrap,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_duty,
  input logic [1:0]                   rdy,
  input logic [1:0]                   ovf
);
  p_pair_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_h & out_l) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |-> (!out_h[c] && !out_l[c]));
    p_duty_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_duty[c]) |-> $past(wrap));
  end

  p_cap_quiet_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csel[0] |-> (!out_h[CAP_A] && !out_l[CAP_A]));
  p_cap_quiet_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csel[1] |-> (!out_h[CAP_B] && !out_l[CAP_B]));

  for (genvar j = 0; j < 2; j++) begin : g_cap
    p_ovf_after_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[j]) |-> $past(rdy[j]));
  end
endmodule

bind pwm_dt_cap pwm_dt_cap_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CAP_A(CAP_A), .CAP_B(CAP_B)
) chk_i (
  .clk(clk), .rst_n(rst_sn), .out_h(out_h), .out_l(out_l), .chan_en(chan_en),
  .csel(csel_q), .wrap(wrap), .act_duty(act_q), .rdy(cap_rdy), .ovf(cap_ovf)
);

// File: tb/pwm_dt_cap_tb_top.sv
module pwm_dt_cap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  cap_in = '0;
  logic [4:0]  out_h, out_l;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pwm_dt_cap dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
    .out_h(out_h), .out_l(out_l)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic count_win(input int n, output int h[5], output int l[5]);
    for (int c = 0; c < 5; c++) begin h[c] = 0; l[c] = 0; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        h[c] += int'(out_h[c]);
        l[c] += int'(out_l[c]);
      end
    end
  endtask

  task automatic wait_rise(input int c);
    logic prev;
    @(negedge clk);
    prev = out_h[c];
    forever begin
      @(negedge clk);
      if (out_h[c] && !prev) break;
      prev = out_h[c];
    end
  endtask

  task automatic wave(input int j, input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) begin
      cap_in[j] = 1'b1;
      repeat (hi) @(negedge clk);
      cap_in[j] = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic cap_case(input int j, input int hi, input int lo);
    logic [31:0] w;
    logic [3:0]  a;
    a = 4'(4 + j);
    cap_in[j] = 1'b0;
    wr(4'd2, 16'h001F);
    wr(4'd2, 16'h031F);
    rd(a, w);
    wave(j, hi, lo, 2);
    repeat (6) @(negedge clk);
    rd(a, w);
    check("R8 ready", w[31], 1);
    check("R9 no overflow", w[15], 0);
    check("R8 period", w[14:0], hi + lo);
    check("R8 high", w[30:16], hi);
    wave(j, hi, lo, 2);
    repeat (6) @(negedge clk);
    rd(a, w);
    check("R9 overflow set", w[15], 1);
    check("R9 newest period", w[14:0], hi + lo);
    check("R9 newest high", w[30:16], hi);
    rd(a, w);
    check("R9 ready cleared", w[31], 0);
    check("R9 overflow cleared", w[15], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int h[5], l[5];
    int dl[6];
    int pv, dv, d, per, eh, el, cnt, hc;
    logic [31:0] w;
    dl = '{0, 1, 8, 128, 200, 255};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_h", out_h, 0);
    check("R1 out_l", out_l, 0);
    rd(4'd2, w); check("R1 control", w, 0);
    rd(4'd4, w); check("R1 capture 0", w, 0);
    rd(4'd5, w); check("R1 capture 1", w, 0);

    // R3/R4 sweep: prescaler x dead time x duty set
    for (int pi = 0; pi < 2; pi++) begin
      for (int di = 0; di < 3; di++) begin
        for (int rot = 0; rot < 2; rot++) begin
          pv = pi;
          dv = (di == 0) ? 0 : ((di == 1) ? 3 : 17);
          per = 256 * (pv + 1);
          wr(4'd0, 16'(pv));
          wr(4'd1, 16'(dv));
          wr(4'd2, 16'h001F);
          for (int c = 0; c < 5; c++) wr(4'(8 + c), 16'(dl[(c + rot) % 6]));
          repeat (3 * per) @(negedge clk);
          count_win(per, h, l);
          for (int c = 0; c < 5; c++) begin
            d = dl[(c + rot) % 6];
            if (d == 0) begin
              eh = 0; el = per;
            end else begin
              eh = d * (pv + 1) - dv; if (eh < 0) eh = 0;
              el = (256 - d) * (pv + 1) - dv; if (el < 0) el = 0;
            end
            check((dv == 0) ? "R3 high time" : "R4 high time after dead time", h[c], eh);
            check((dv == 0) ? "R3 low time" : "R4 low time after dead time", l[c], el);
          end
        end
      end
    end

    // R6: channel 3 disabled
    wr(4'd2, 16'h0017);
    count_win(600, h, l);
    check("R6 disabled high side", h[3], 0);
    check("R6 disabled low side", l[3], 0);
    check("R6 enabled neighbour active", h[2] + l[2] > 0, 1);

    // R2: prescaler 3, duty 64
    wr(4'd0, 16'd3); wr(4'd1, 16'd0); wr(4'd2, 16'h001F); wr(4'd9, 16'd64);
    repeat (2100) @(negedge clk);
    wait_rise(1);
    cnt = 1; hc = 1;
    forever begin
      @(negedge clk);
      if (out_h[1] && !out_l[1] && hc == cnt) begin hc++; cnt++; end
      else if (!out_h[1]) cnt++;
      else break;
    end
    check("R2 period length", cnt, 1024);
    check("R2 high length", hc, 256);

    // R5: duty change mid-period waits for the wrap
    wr(4'd0, 16'd0); wr(4'd10, 16'd200);
    repeat (800) @(negedge clk);
    wait_rise(2);
    repeat (100) @(negedge clk);
    wr(4'd10, 16'd50);
    cnt = 0;
    for (int k = 0; k < 80; k++) begin @(negedge clk); cnt += int'(out_h[2]); end
    check("R5 running period keeps old duty", cnt, 80);
    wait_rise(2);
    cnt = 1;
    for (int k = 1; k < 256; k++) begin @(negedge clk); cnt += int'(out_h[2]); end
    check("R5 new duty after wrap", cnt, 50);

    // R7: capture mode silences channels 0 and 4
    wr(4'd2, 16'h031F);
    count_win(300, h, l);
    check("R7 channel 0 quiet", h[0] + l[0], 0);
    check("R7 channel 4 quiet", h[4] + l[4], 0);
    rd(4'd2, w);
    check("R7 control readback", w, 32'h31F);

    // R8/R9: measurements on both units
    cap_case(0, 5, 7);
    cap_case(0, 20, 3);
    cap_case(0, 1, 1);
    cap_case(0, 100, 60);
    cap_case(1, 9, 4);
    cap_case(1, 2, 30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule